// File: doc/BRIEF.md
# Quota-Enforcing Victim Way Selector

This block picks the way to evict when a core misses in one set of a shared set-associative cache whose ways are split between cores by quota. Each line of the set carries a valid bit, the id of the core that filled it and a recency age, where a larger age means less recently used. The block also receives the id of the missing core and a table of per-core way quotas. It returns the index of the way to replace.

Empty ways are used first. When the set is full, the block counts the lines the missing core already holds. If the core is below its quota, it takes a line from the other cores. Otherwise it recycles one of its own. Within the chosen pool, the oldest line is evicted. The quotas themselves, and the age updates after the fill, are produced elsewhere.

A miss is presented as a one-cycle strobe together with the set's state. The answer appears on registered outputs one clock later.

Top module: `wayq_victim_pick`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first strobe, `victim_vld` is 0 and `victim_way` is 0.
- R2: `victim_vld` is 1 in the cycle after each cycle in which `miss_vld` is 1, and 0 in the cycle after each cycle in which `miss_vld` is 0. `victim_way` is registered with the same timing.
- R3: If any bit of `line_vld` is 0, the victim is the lowest-numbered way whose valid bit is 0, regardless of owners, ages and quotas.
- R4: If all ways are valid, and the number of lines whose owner field equals `req_core` is strictly less than the requester's quota, the victim is the oldest line (largest age) among the lines owned by other cores.
- R5: If all ways are valid, and the requester's line count is greater than or equal to its quota, the victim is the oldest line among the requester's own lines.
- R6: If the pool selected by R4 or R5 contains no line, the victim is the oldest line of the whole set.
- R7: When several lines in the pool share the largest age, the lowest way index among them is chosen.
- R8: Way i's owner id is `line_owner[i*CID_W +: CID_W]` and its age is `line_age[i*AGE_W +: AGE_W]`. Core c's quota is `quota[c*CNT_W +: CNT_W]`, where CNT_W = clog2(WAYS+1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_vld | input | 1 | Miss strobe; the set state is sampled in the same cycle |
| req_core | input | CID_W | Id of the missing core |
| line_vld | input | WAYS | Valid bit per way |
| line_owner | input | WAYS*CID_W | Owner core id per way |
| line_age | input | WAYS*AGE_W | Recency age per way; larger means older |
| quota | input | CORES*CNT_W | Allocated way count per core |
| victim_vld | output | 1 | Victim result valid, one cycle after the strobe |
| victim_way | output | WAY_W | Chosen way index |

## Verification
The bench builds the block with four ways, two cores and 2-bit ages, so a full set has only 16 ownership patterns and 256 age vectors. Every one of them is swept for both requesters and every quota split from 0/4 to 4/0. This reaches the quota boundary from both sides, empty pools that force the global fallback, and every possible tie in age. A second sweep walks all partly valid sets against all owner patterns to cover empty-way priority, and idle cycles between strobes check that the result flag drops.

// File: rtl/wayq_victim_pick.sv
module wayq_victim_pick #(
  parameter int WAYS  = 16,
  parameter int CORES = 2,
  parameter int AGE_W = 4,
  localparam int CID_W = (CORES > 1) ? $clog2(CORES) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int CNT_W = $clog2(WAYS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   miss_vld,
  input  logic [CID_W-1:0]       req_core,
  input  logic [WAYS-1:0]        line_vld,
  input  logic [WAYS*CID_W-1:0]  line_owner,
  input  logic [WAYS*AGE_W-1:0]  line_age,
  input  logic [CORES*CNT_W-1:0] quota,
  output logic                   victim_vld,
  output logic [WAY_W-1:0]       victim_way
);

  logic [WAYS-1:0]  mine, other, pool, cand;
  logic [CNT_W-1:0] own_cnt, req_quota;
  logic             under, full;
  logic [WAY_W-1:0] inv_way, old_way, pick_way;
  logic [AGE_W-1:0] old_age;
  logic             old_found;

  for (genvar i = 0; i < WAYS; i++) begin : g_own
    assign mine[i] = line_vld[i] && (line_owner[i*CID_W +: CID_W] == req_core);
  end

  assign other     = line_vld & ~mine;
  assign own_cnt   = CNT_W'($countones(mine));
  assign req_quota = quota[req_core*CNT_W +: CNT_W];
  assign under     = own_cnt < req_quota;
  assign full      = &line_vld;
  assign pool      = under ? other : mine;
  assign cand      = (pool != '0) ? pool : line_vld;

  always_comb begin
    inv_way = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (!line_vld[i]) inv_way = WAY_W'(i);
  end

  always_comb begin
    old_way   = '0;
    old_age   = '0;
    old_found = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (cand[i] && (!old_found || line_age[i*AGE_W +: AGE_W] > old_age)) begin
        old_way   = WAY_W'(i);
        old_age   = line_age[i*AGE_W +: AGE_W];
        old_found = 1'b1;
      end
    end
  end

  assign pick_way = full ? old_way : inv_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      victim_vld <= 1'b0;
      victim_way <= '0;
    end else begin
      victim_vld <= miss_vld;
      if (miss_vld) victim_way <= pick_way;
    end
  end

  logic [WAYS-1:0] snap_vld, snap_mine, snap_other;
  logic            snap_under;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_vld   <= '1;
      snap_mine  <= '0;
      snap_other <= '0;
      snap_under <= 1'b0;
    end else if (miss_vld) begin
      snap_vld   <= line_vld;
      snap_mine  <= mine;
      snap_other <= other;
      snap_under <= under;
    end
  end

  a_r2_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    miss_vld |=> victim_vld);

  a_r2_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_vld |=> !victim_vld);

  a_r3_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_vld && !(&snap_vld)) |-> !snap_vld[victim_way]);

  a_r4_other_pool: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_vld && (&snap_vld) && snap_under && (snap_other != '0)) |-> !snap_mine[victim_way]);

  a_r5_own_pool: assert property (@(posedge clk) disable iff (!rst_n)
    (victim_vld && (&snap_vld) && !snap_under && (snap_mine != '0)) |-> snap_mine[victim_way]);

endmodule

// File: tb/tb_wayq_victim_pick.sv
`timescale 1ns/1ps
module tb_wayq_victim_pick;
  localparam int WAYS = 4, CORES = 2, AGE_W = 2, CID_W = 1, WAY_W = 2, CNT_W = 3;

  logic clk = 0, rst_n = 0, miss_vld = 0;
  logic [CID_W-1:0] req_core = '0;
  logic [WAYS-1:0] line_vld = '1;
  logic [WAYS*CID_W-1:0] line_owner = '0;
  logic [WAYS*AGE_W-1:0] line_age = '0;
  logic [CORES*CNT_W-1:0] quota = '0;
  logic victim_vld;
  logic [WAY_W-1:0] victim_way;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wayq_victim_pick #(.WAYS(WAYS), .CORES(CORES), .AGE_W(AGE_W)) dut (
    .clk(clk), .rst_n(rst_n), .miss_vld(miss_vld), .req_core(req_core),
    .line_vld(line_vld), .line_owner(line_owner), .line_age(line_age),
    .quota(quota), .victim_vld(victim_vld), .victim_way(victim_way));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      if (errors < 20) $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] v, input logic [3:0] o, input logic [7:0] a,
                       input int r, input int q, output int way, output string tag);
    int cnt, best, nmax;
    logic [3:0] m, p;
    m = '0;
    for (int i = 0; i < 4; i++) m[i] = v[i] && (o[i] == r[0]);
    if (v != 4'hF) begin
      for (int i = 3; i >= 0; i--) if (!v[i]) way = i;
      tag = "R3";
      return;
    end
    cnt = 0;
    for (int i = 0; i < 4; i++) cnt += m[i];
    p = (cnt < q) ? ~m : m;
    tag = (cnt < q) ? "R4" : "R5";
    if (p == 0) begin p = 4'hF; tag = "R6"; end
    best = -1; way = 0; nmax = 0;
    for (int i = 0; i < 4; i++)
      if (p[i] && int'(a[2*i +: 2]) > best) begin best = a[2*i +: 2]; way = i; end
    for (int i = 0; i < 4; i++) if (p[i] && int'(a[2*i +: 2]) == best) nmax++;
    if (nmax > 1) tag = {tag, "/R7"};
  endtask

  task automatic apply(input logic [3:0] v, input logic [3:0] o, input logic [7:0] a,
                       input int r, input int q);
    int ew;
    string tag;
    line_vld = v; line_owner = o; line_age = a; req_core = r[0];
    quota = '0;
    quota[r*CNT_W +: CNT_W] = CNT_W'(q);
    quota[(1-r)*CNT_W +: CNT_W] = CNT_W'(WAYS - q);
    miss_vld = 1;
    model(v, o, a, r, q, ew, tag);
    @(negedge clk);
    check("R2", victim_vld, 1);
    check({tag, " (R8 fields)"}, victim_way, ew);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", victim_vld, 0);
    check("R1", victim_way, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", victim_vld, 0);
    check("R1", victim_way, 0);

    for (int r = 0; r < 2; r++)
      for (int q = 0; q <= WAYS; q++)
        for (int o = 0; o < 16; o++)
          for (int a = 0; a < 256; a++)
            apply(4'hF, 4'(o), 8'(a), r, q);

    for (int v = 0; v < 15; v++)
      for (int o = 0; o < 16; o++)
        for (int r = 0; r < 2; r++)
          apply(4'(v), 4'(o), 8'hE4, r, 2);

    miss_vld = 0;
    line_vld = 4'h0;
    @(negedge clk);
    check("R2 quiet", victim_vld, 0);
    @(negedge clk);
    check("R2 quiet", victim_vld, 0);
    apply(4'hF, 4'b0101, 8'b00_11_01_11, 0, 1);
    miss_vld = 0;
    @(negedge clk);
    check("R2 quiet after strobe", victim_vld, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule